// File: doc/BRIEF.md
# Sticky Limit-Violation Interrupt Status Register

This block holds an 8-bit interrupt status word for a monitoring chip. Five measurement channels are tracked: three temperatures and two supply voltages. Each channel reports a live limit-violation flag and a strobe that marks a fresh reading. A channel's status bit latches when a fresh reading violates its limits and that channel's own enable is set. The bit then stays latched until software reads the word, or until the enable-off rule clears it.

A read clears a latched bit on the following clock edge, but only when that channel is no longer in violation. The data seen during the read cycle is the value from before the clear. A bit whose enable has been turned off is dropped at that channel's next reading. Readings only happen while the conversion START control is 1. The top bit is a live flag that is 1 whenever any bit of a companion (second) status register is set. Two bit positions are reserved and always read 0. The word has no write path.

Top module: `viol_irq_status`

## Requirements
- R1: Reset clears the register. With the second-register input at zero, the word reads 00h.
- R2: Bit layout: bit 1 is channel 0 (core supply), bit 2 is channel 1 (main supply), bit 4 is channel 2 (diode 1), bit 5 is channel 3 (ambient) and bit 6 is channel 4 (diode 2). Bits 0 and 3 always read 0.
- R3: A channel's bit becomes 1 on the edge that ends a cycle in which START=1, its update strobe is 1, its violation flag is 1 and its enable is 1.
- R4: A channel's bit never goes from 0 to 1 while its enable is 0, whatever the violation flag shows.
- R5: A set bit stays 1 after its violation flag returns to 0, as long as no read and no disabled-channel reading occurs.
- R6: During a read-strobe cycle the word shows its value from before the read. On the next edge, each set bit whose violation flag is 0 clears. A bit whose flag is still 1 stays 1.
- R7: A set bit whose enable is 0 clears on the first edge at which START=1 and its update strobe is 1. While START=0, or while no update arrives, it stays set.
- R8: Bit 7 equals the OR of all bits of the second status register input, in the same cycle.
- R9: A qualifying new violation in a read cycle wins over the clear, so the bit is 1 after the read.
- R10: An update strobe while START=0 neither sets nor clears any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 5 | Per-channel reading-update strobe |
| viol_i | input | 5 | Per-channel live limit-violation flag |
| en_i | input | 5 | Per-channel individual interrupt enable |
| start_i | input | 1 | Conversion START control; readings update only while 1 |
| rd_i | input | 1 | Software read strobe for the status word |
| sec_stat_i | input | 8 | Contents of the second status register |
| stat_o | output | 8 | Status word as seen by software |

## Verification
Two things can fall in the same edge: a read-triggered clear, and a set or enable-off clear for the same bit. The bench provokes this by raising the read strobe in the same cycle as a qualifying violation, with other channels still in violation or already quiet. It then judges the word on the following cycle against the priority rule: a set wins, and only quiet bits clear. It also samples the word inside the read cycle itself, to confirm that the pre-clear value is what software sees.

// File: rtl/viol_irq_pkg.sv
package viol_irq_pkg;

   typedef enum logic [1:0] {
      CELL_HOLD    = 2'd0,
      CELL_SET     = 2'd1,
      CELL_CLR_RD  = 2'd2,
      CELL_CLR_DIS = 2'd3
   } cell_act_e;

endpackage

// File: rtl/viol_irq_cell.sv
module viol_irq_cell
   import viol_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic meas_i,
   input  logic viol_i,
   input  logic en_i,
   input  logic rd_i,
   output logic flag_o
);

   cell_act_e act;

   always_comb begin
      if (meas_i && viol_i && en_i)
         act = CELL_SET;
      else if (!flag_o)
         act = CELL_HOLD;
      else if (meas_i && !en_i)
         act = CELL_CLR_DIS;
      else if (rd_i && !viol_i)
         act = CELL_CLR_RD;
      else
         act = CELL_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else begin
         case (act)
            CELL_SET:     flag_o <= 1'b1;
            CELL_CLR_RD,
            CELL_CLR_DIS: flag_o <= 1'b0;
            default:      flag_o <= flag_o;
         endcase
      end
   end

endmodule

// File: rtl/viol_irq_pack.sv
module viol_irq_pack #(
   parameter int REG_W   = 8,
   parameter int N_CH    = 5,
   localparam int POS_W  = $clog2(REG_W),
   parameter logic [N_CH*POS_W-1:0] CH_MAP = {3'd6, 3'd5, 3'd4, 3'd2, 3'd1},
   parameter int SUM_POS = 7
) (
   input  logic [N_CH-1:0]  flags_i,
   input  logic             summ_i,
   output logic [REG_W-1:0] word_o
);

   always_comb begin
      word_o = '0;
      for (int c = 0; c < N_CH; c++) begin
         word_o[CH_MAP[c*POS_W +: POS_W]] = flags_i[c];
      end
      word_o[SUM_POS] = summ_i;
   end

endmodule

// File: rtl/viol_irq_status.sv
module viol_irq_status #(
   parameter int REG_W   = 8,
   parameter int N_CH    = 5,
   parameter int SEC_W   = 8,
   localparam int POS_W  = $clog2(REG_W),
   parameter logic [N_CH*POS_W-1:0] CH_MAP = {3'd6, 3'd5, 3'd4, 3'd2, 3'd1},
   parameter int SUM_POS = 7,
   parameter bit SUM_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CH-1:0]  upd_i,
   input  logic [N_CH-1:0]  viol_i,
   input  logic [N_CH-1:0]  en_i,
   input  logic             start_i,
   input  logic             rd_i,
   input  logic [SEC_W-1:0] sec_stat_i,
   output logic [REG_W-1:0] stat_o
);

   // elaboration-time parameter checks
   if (N_CH + 1 > REG_W) begin : g_err_fit
      $error("viol_irq_status: channels plus summary exceed REG_W");
   end
   if (SUM_POS >= REG_W) begin : g_err_sum
      $error("viol_irq_status: SUM_POS outside the word");
   end
   for (genvar i = 0; i < N_CH; i++) begin : g_chk_map
      if (int'(CH_MAP[i*POS_W +: POS_W]) == SUM_POS) begin : g_err_ovl
         $error("viol_irq_status: channel mapped onto summary bit");
      end
      for (genvar j = i + 1; j < N_CH; j++) begin : g_pair
         if (CH_MAP[i*POS_W +: POS_W] == CH_MAP[j*POS_W +: POS_W]) begin : g_err_dup
            $error("viol_irq_status: two channels share a bit");
         end
      end
   end

   logic [N_CH-1:0] flags;
   logic            summ;

   for (genvar c = 0; c < N_CH; c++) begin : g_cell
      viol_irq_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .meas_i (upd_i[c] & start_i),
         .viol_i (viol_i[c]),
         .en_i   (en_i[c]),
         .rd_i   (rd_i),
         .flag_o (flags[c])
      );
   end

   if (SUM_REG) begin : g_sum_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) summ <= 1'b0;
         else        summ <= |sec_stat_i;
      end
   end else begin : g_sum_live
      assign summ = |sec_stat_i;
   end

   viol_irq_pack #(
      .REG_W   (REG_W),
      .N_CH    (N_CH),
      .CH_MAP  (CH_MAP),
      .SUM_POS (SUM_POS)
   ) u_pack (
      .flags_i (flags),
      .summ_i  (summ),
      .word_o  (stat_o)
   );

endmodule

// File: rtl/viol_irq_status_chk.sv
module viol_irq_status_chk #(
   parameter int REG_W   = 8,
   parameter int N_CH    = 5,
   parameter int SEC_W   = 8,
   localparam int POS_W  = $clog2(REG_W),
   parameter logic [N_CH*POS_W-1:0] CH_MAP = {3'd6, 3'd5, 3'd4, 3'd2, 3'd1},
   parameter int SUM_POS = 7,
   parameter bit SUM_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_CH-1:0]  upd_i,
   input logic [N_CH-1:0]  viol_i,
   input logic [N_CH-1:0]  en_i,
   input logic             start_i,
   input logic             rd_i,
   input logic [SEC_W-1:0] sec_stat_i,
   input logic [REG_W-1:0] stat_o
);

   function automatic logic [REG_W-1:0] used_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int c = 0; c < N_CH; c++) m[CH_MAP[c*POS_W +: POS_W]] = 1'b1;
      m[SUM_POS] = 1'b1;
      return m;
   endfunction

   localparam logic [REG_W-1:0] USED = used_mask();

   // R2: unmapped bits never read 1
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o & ~USED) == '0);

   if (!SUM_REG) begin : g_live_sum
      // R8: summary bit follows the second register in the same cycle
      a_r8_summary_live: assert property (@(posedge clk) disable iff (!rst_n)
         stat_o[SUM_POS] == (|sec_stat_i));
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam int P = int'(CH_MAP[c*POS_W +: POS_W]);

      a_r3_set_on_update: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_i[c] && start_i && viol_i[c] && en_i[c]) |=> stat_o[P]);

      a_r4_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_o[P] && !en_i[c]) |=> !stat_o[P]);

      a_r5_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_o[P] && !rd_i && !(upd_i[c] && start_i && !en_i[c])) |=> stat_o[P]);

      a_r6_keep_active_on_read: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_o[P] && rd_i && viol_i[c]) |=> stat_o[P]);

      a_r10_no_set_without_reading: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_o[P] && !(upd_i[c] && start_i)) |=> !stat_o[P]);
   end

endmodule

bind viol_irq_status viol_irq_status_chk #(
   .REG_W   (REG_W),
   .N_CH    (N_CH),
   .SEC_W   (SEC_W),
   .CH_MAP  (CH_MAP),
   .SUM_POS (SUM_POS),
   .SUM_REG (SUM_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_i      (upd_i),
   .viol_i     (viol_i),
   .en_i       (en_i),
   .start_i    (start_i),
   .rd_i       (rd_i),
   .sec_stat_i (sec_stat_i),
   .stat_o     (stat_o)
);

// File: tb/viol_irq_status_test.sv
module viol_irq_status_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] upd_i = '0, viol_i = '0, en_i = '0;
   logic       start_i = 1'b0, rd_i = 1'b0;
   logic [7:0] sec_stat_i = '0;
   logic [7:0] stat_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   viol_irq_status uut (
      .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .viol_i(viol_i), .en_i(en_i),
      .start_i(start_i), .rd_i(rd_i), .sec_stat_i(sec_stat_i), .stat_o(stat_o)
   );

   // {upd[4:0], viol[4:0], en[4:0], start, rd, sec[7:0], expected word after edge}
   // channel bit positions: ch0->1, ch1->2, ch2->4, ch3->5, ch4->6; summary bit 7
   localparam int NV = 16;
   localparam logic [32:0] VEC [NV] = '{
      {5'b00000, 5'b00000, 5'b11111, 1'b0, 1'b0, 8'h00, 8'h00}, // R1 idle
      {5'b00001, 5'b00001, 5'b11111, 1'b1, 1'b0, 8'h00, 8'h02}, // R3 ch0 sets
      {5'b00000, 5'b00000, 5'b11111, 1'b1, 1'b0, 8'h00, 8'h02}, // R5 held
      {5'b00010, 5'b00010, 5'b11101, 1'b1, 1'b0, 8'h00, 8'h02}, // R4 ch1 disabled
      {5'b11111, 5'b11111, 5'b11111, 1'b0, 1'b0, 8'h00, 8'h02}, // R10 START=0
      {5'b11100, 5'b11100, 5'b11111, 1'b1, 1'b0, 8'h00, 8'h72}, // R3 ch2..4
      {5'b00000, 5'b00100, 5'b11111, 1'b1, 1'b1, 8'h00, 8'h10}, // R6 ch2 active stays
      {5'b00000, 5'b00000, 5'b11111, 1'b1, 1'b0, 8'h04, 8'h90}, // R8 summary on
      {5'b00000, 5'b00000, 5'b11111, 1'b1, 1'b0, 8'h00, 8'h10}, // R8 summary off
      {5'b00100, 5'b00000, 5'b11011, 1'b0, 1'b0, 8'h00, 8'h10}, // R7 START=0 keeps
      {5'b00000, 5'b00000, 5'b11011, 1'b1, 1'b0, 8'h00, 8'h10}, // R7 no update keeps
      {5'b00100, 5'b00000, 5'b11011, 1'b1, 1'b0, 8'h00, 8'h00}, // R7 update clears
      {5'b00001, 5'b00001, 5'b11111, 1'b1, 1'b1, 8'h00, 8'h02}, // R9 set beats read
      {5'b00000, 5'b00000, 5'b11111, 1'b1, 1'b1, 8'h00, 8'h00}, // R6 quiet clears
      {5'b11111, 5'b11111, 5'b11111, 1'b1, 1'b0, 8'hFF, 8'hF6}, // R2 reserved zero
      {5'b00000, 5'b00000, 5'b11111, 1'b1, 1'b1, 8'h00, 8'h00}  // R6 all clear
   };
   localparam int VREQ [NV] = '{1, 3, 5, 4, 10, 3, 6, 8, 8, 7, 7, 7, 9, 6, 2, 6};

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: stat_o=%02h expected %02h", req, act, exp);
      end
   endtask

   task automatic idle();
      upd_i = '0; viol_i = '0; rd_i = 1'b0; sec_stat_i = '0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", stat_o, 8'h00);             // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         {upd_i, viol_i, en_i, start_i, rd_i, sec_stat_i} = VEC[v][32:8];
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VREQ[v], v), stat_o, VEC[v][7:0]);
      end

      // R6: read cycle shows the pre-clear value, clear lands on the next edge
      idle(); en_i = 5'b11111; start_i = 1'b1;
      upd_i = 5'b10000; viol_i = 5'b10000;
      @(negedge clk);
      idle(); rd_i = 1'b1;
      #1 check("R6 pre-clear read data", stat_o, 8'h40);
      @(negedge clk);
      check("R6 clear after read", stat_o, 8'h00);

      // R7: disabled set bit survives many START=0 updates, clears once START=1
      idle(); upd_i = 5'b00010; viol_i = 5'b00010;
      @(negedge clk);
      idle(); en_i = 5'b11101; start_i = 1'b0; upd_i = 5'b00010;
      repeat (4) @(negedge clk);
      check("R7 held while START=0", stat_o, 8'h04);
      start_i = 1'b1;
      @(negedge clk);
      check("R7 cleared at START=1 update", stat_o, 8'h00);

      // R4: enable 0 with repeated violating updates never sets
      idle(); upd_i = 5'b01000; viol_i = 5'b01000; en_i = 5'b10111;
      repeat (3) @(negedge clk);
      check("R4 disabled never sets", stat_o, 8'h00);

      // R1: reset drops latched bits
      en_i = 5'b11111;
      @(negedge clk);
      check("R3 ch3 sets", stat_o, 8'h20);
      idle(); rst_n = 1'b0;
      #1 check("R1 reset clears", stat_o, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, got done=0 expected 1");
         summary();
         $finish;
      end
   end

endmodule